// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a single-beat host request port and an asynchronous static RAM with 19 address lines, 8 shared data lines and active-low select, write and output-enable strobes. Each accepted request becomes one strobe sequence, and every phase lasts a whole number of clock cycles. The controller takes each phase length as a nanosecond limit and converts it to cycles at elaboration time: the ceiling of the limit divided by the clock period, with at least one cycle per phase.

The host presents a request with `req_valid_i` high. The request is taken on a clock edge where `req_ready_o` is also high, which happens only when the controller is idle. Address and write data are registered when the request is accepted and stay on the pins until the next request is accepted. Writes keep output enable high for the whole pulse, so the shorter write-pulse minimum applies. The controller drives the data lines itself only inside the write window. After every read it waits a set number of turnaround cycles, so the RAM has released the data lines before any later write drives them. Read data is registered at the end of the access wait and is presented together with a one-cycle done pulse.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted, `sram_cs_no`, `sram_we_no` and `sram_oe_no` are 1, `sram_dq_oe_o` is 0, `rsp_done_o` is 0 and `req_ready_o` is 1.
- R2: Throughout a write window (`sram_we_no`=0), `sram_cs_no`=0, `sram_oe_no`=1, `sram_dq_oe_o`=1, and `sram_dq_o` carries the data of the accepted write.
- R3: The write strobe is low for exactly WP cycles, where WP is the larger of the pulse-width and data-setup limits in cycles (2 at the defaults: 7 ns and 5 ns at 5 ns per clock). It starts in the first cycle after the accepting edge.
- R4: `sram_addr_o` equals the accepted request address from the first strobe cycle until the next request is accepted. It does not change while `sram_cs_no` stays low.
- R5: After a write, select and write are high and the driver is off for REC = max(1, write-cycle cycles − WP) cycles. The next cycle shows `rsp_done_o`=1 and `req_ready_o`=1. That cycle is WP+REC+1 cycles after acceptance (4 at the defaults).
- R6: A read holds `sram_cs_no`=0, `sram_oe_no`=0, `sram_we_no`=1 and `sram_dq_oe_o`=0 for exactly AA cycles. AA is the largest of the address-access, read-cycle and output-enable-access limits in cycles (2 at the defaults).
- R7: Read data is sampled from `sram_dq_i` on the edge that ends the AA window. In the next cycle it appears on `rsp_rdata_o` with a one-cycle `rsp_done_o`. It is held unchanged until the next read completes, and writes do not alter it.
- R8: After a read ends, select and output enable are high and `req_ready_o` stays 0 for TA cycles, where TA is the output-release limit in cycles (1 at the defaults).
- R9: `sram_dq_oe_o` is never 1 while `sram_oe_no` is 0.
- R10: A request is taken only when `req_valid_i` and `req_ready_o` are both 1. While the controller is idle, all strobes are high and the driver is off.
- R11: Every accepted request yields exactly one `rsp_done_o` pulse, and that pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Request word address |
| req_wdata_i | input | 8 | Write data |
| req_ready_o | output | 1 | Controller idle, request taken this edge if valid |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 8 | Data of the last completed read |
| sram_addr_o | output | 19 | RAM address pins |
| sram_cs_no | output | 1 | RAM chip select, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 8 | Data toward the RAM |
| sram_dq_oe_o | output | 1 | Tri-state enable for `sram_dq_o` |
| sram_dq_i | input | 8 | Data from the RAM lines |

## Verification
All counts below are taken from the accepting edge. Write strobes are due in cycles 1 to WP, recovery in the next REC cycles, and done with ready in cycle WP+REC+1. Read strobes are due in cycles 1 to AA, done and data in cycle AA+1, and ready again in cycle AA+TA+1. The bench derives WP, REC, AA and TA from the nanosecond limits with its own ceiling function. It steps one falling edge per cycle after acceptance and compares every pin against the value expected for that cycle index, so an early or late edge is caught in the cycle where it happens. The RAM model holds invalid data until the read strobes have been held for AA−1 full cycles, so a capture made one edge early returns the wrong byte.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_WREC,
    ST_RD,
    ST_TURN
  } ctl_state_e;

  // ceiling of ns limit over clock period, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned WP_CYC  = 2,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned AA_CYC  = 2,
  parameter int unsigned TA_CYC  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             done_o,
  output logic             cs_no,
  output logic             we_no,
  output logic             oe_no,
  output logic             dq_oe_o
);

  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] AA_LD  = CNT_W'(AA_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);

  ctl_state_e state_q, state_d;
  logic       done_d;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    capture_o  = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = req_write_i ? WP_LD : AA_LD;
        state_d    = req_write_i ? ST_WR : ST_RD;
      end
      ST_WR: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = REC_LD;
        state_d    = ST_WREC;
      end
      ST_WREC: if (tmr_zero_i) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RD: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        tmr_val_o  = TA_LD;
        capture_o  = 1'b1;
        done_d     = 1'b1;
        state_d    = ST_TURN;
      end
      ST_TURN: if (tmr_zero_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state so pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_no   <= 1'b1;
      we_no   <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_no   <= !((state_d == ST_WR) || (state_d == ST_RD));
      we_no   <= !(state_d == ST_WR);
      oe_no   <= !(state_d == ST_RD);
      dq_oe_o <= (state_d == ST_WR);
      done_o  <= done_d;
    end
  end

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      dq_o   <= '0;
    end else if (accept_i) begin
      addr_o <= addr_i;
      dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (capture_i) rdata_o <= dq_i;
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_PS  = 5000,
  parameter int unsigned T_WP_NS = 7,
  parameter int unsigned T_DW_NS = 5,
  parameter int unsigned T_WC_NS = 10,
  parameter int unsigned T_AA_NS = 10,
  parameter int unsigned T_RC_NS = 10,
  parameter int unsigned T_OE_NS = 5,
  parameter int unsigned T_HZ_NS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned WP_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_PS), ns_to_cyc(T_DW_NS, CLK_PS));
  localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PS);
  localparam int unsigned REC_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned AA_CYC  = max2(max2(ns_to_cyc(T_AA_NS, CLK_PS), ns_to_cyc(T_RC_NS, CLK_PS)),
                                         ns_to_cyc(T_OE_NS, CLK_PS));
  localparam int unsigned TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_PS);
  localparam int unsigned MAX_CYC = max2(max2(WP_CYC, REC_CYC), max2(AA_CYC, TA_CYC));
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_ctl_fsm #(
    .CNT_W   (CNT_W),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .AA_CYC  (AA_CYC),
    .TA_CYC  (TA_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .accept_o    (accept),
    .capture_o   (capture),
    .ready_o     (req_ready_o),
    .done_o      (rsp_done_o),
    .cs_no       (sram_cs_no),
    .we_no       (sram_we_no),
    .oe_no       (sram_oe_no),
    .dq_oe_o     (sram_dq_oe_o)
  );

  sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .dq_i      (sram_dq_i),
    .addr_o    (sram_addr_o),
    .dq_o      (sram_dq_o),
    .rdata_o   (rsp_rdata_o)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned WP_MIN = 2,
  parameter int unsigned AA_MIN = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_cs_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic              sram_dq_oe_o
);

  logic [7:0] wlow_q, rlow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wlow_q <= '0;
      rlow_q <= '0;
    end else begin
      wlow_q <= sram_we_no ? 8'd0 : ((wlow_q == 8'hff) ? wlow_q : wlow_q + 8'd1);
      rlow_q <= sram_oe_no ? 8'd0 : ((rlow_q == 8'hff) ? rlow_q : rlow_q + 8'd1);
    end
  end

  // R9
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  // R2
  wr_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_cs_no && sram_oe_no && sram_dq_oe_o));

  // R3
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (wlow_q >= 8'(WP_MIN)));

  // R6
  rd_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> (rlow_q >= 8'(AA_MIN)));

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |-> $stable(sram_addr_o));

  // R10
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_cs_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  // R8
  turn_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> !req_ready_o);

endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W (ADDR_W),
  .WP_MIN (WP_CYC),
  .AA_MIN (AA_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .rsp_done_o   (rsp_done_o),
  .sram_addr_o  (sram_addr_o),
  .sram_cs_no   (sram_cs_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

  function automatic int cyc_of(input int ns);
    int c;
    c = (ns * 1000 + 4999) / 5000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int WP_E  = (cyc_of(7) > cyc_of(5)) ? cyc_of(7) : cyc_of(5);
  localparam int REC_E = (cyc_of(10) > WP_E) ? cyc_of(10) - WP_E : 1;
  localparam int AA_E  = (cyc_of(10) > cyc_of(5)) ? cyc_of(10) : cyc_of(5);
  localparam int TA_E  = cyc_of(5);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, wr;
  logic [18:0] addr;
  logic [7:0]  wdata;
  logic        ready, done, cs_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [18:0] s_addr;

  int n_chk  = 0;
  int n_fail = 0;
  int rd_age = 0;
  logic [7:0] ram     [256];
  logic [7:0] exp_mem [256];
  logic [7:0] last_rd;

  always #2.5 clk = ~clk;

  sram_ctl uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (valid),
    .req_write_i  (wr),
    .req_addr_i   (addr),
    .req_wdata_i  (wdata),
    .req_ready_o  (ready),
    .rsp_done_o   (done),
    .rsp_rdata_o  (rdata),
    .sram_addr_o  (s_addr),
    .sram_cs_no   (cs_n),
    .sram_we_no   (we_n),
    .sram_oe_no   (oe_n),
    .sram_dq_o    (dq_o),
    .sram_dq_oe_o (dq_oe),
    .sram_dq_i    (dq_i)
  );

  // RAM model: read data valid only after the read strobes have settled
  always @(posedge clk) begin
    if (!cs_n && !we_n && dq_oe) ram[s_addr[7:0]] <= dq_o;
    if (!cs_n && !oe_n && we_n) rd_age <= rd_age + 1;
    else                        rd_age <= 0;
  end
  assign dq_i = (!cs_n && !oe_n && we_n && rd_age >= AA_E - 1) ? ram[s_addr[7:0]] : 8'hEE;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [18:0] map_addr(input logic [7:0] idx);
    return {idx, 3'b101, idx};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // tasks start and end just after a falling edge
  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    check(ready === 1'b1, "R10 ready before write", int'(ready), 1);
    valid = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; addr = ~a; wdata = ~d;
    exp_mem[a[7:0]] = d;
    for (int k = 1; k <= WP_E + REC_E + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= WP_E) begin
        check({cs_n, we_n, oe_n, dq_oe} === 4'b0011, "R2 R3 write strobes", {cs_n, we_n, oe_n, dq_oe}, 4'b0011);
        check(dq_o === d, "R2 write data", dq_o, d);
        check(s_addr === a, "R4 write address", s_addr, a);
      end else if (k <= WP_E + REC_E) begin
        check({cs_n, we_n, dq_oe, done, ready} === 5'b11000, "R5 write recovery", {cs_n, we_n, dq_oe, done, ready}, 5'b11000);
      end else begin
        check({done, ready} === 2'b11, "R5 R11 write done", {done, ready}, 2'b11);
        check(rdata === last_rd, "R7 rdata held over write", rdata, last_rd);
        check(s_addr === a, "R4 address held", s_addr, a);
      end
    end
  endtask

  task automatic do_read(input logic [18:0] a);
    check(ready === 1'b1, "R10 ready before read", int'(ready), 1);
    valid = 1'b1; wr = 1'b0; addr = a; wdata = 8'h00;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; addr = ~a;
    for (int k = 1; k <= AA_E + TA_E + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= AA_E) begin
        check({cs_n, we_n, oe_n, dq_oe, done} === 5'b01000, "R6 read strobes", {cs_n, we_n, oe_n, dq_oe, done}, 5'b01000);
        check(s_addr === a, "R4 read address", s_addr, a);
      end else if (k <= AA_E + TA_E) begin
        check({cs_n, oe_n, ready} === 3'b110, "R8 turnaround", {cs_n, oe_n, ready}, 3'b110);
        if (k == AA_E + 1) begin
          check(done === 1'b1, "R7 R11 read done", int'(done), 1);
          check(rdata === exp_mem[a[7:0]], "R7 read data", rdata, exp_mem[a[7:0]]);
        end else
          check(done === 1'b0, "R11 single done", int'(done), 0);
      end else begin
        check({ready, done} === 2'b10, "R8 ready after turnaround", {ready, done}, 2'b10);
      end
    end
    last_rd = exp_mem[a[7:0]];
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check({cs_n, we_n, oe_n, dq_oe, done, ready} === 6'b111001, "R10 idle pins",
            {cs_n, we_n, oe_n, dq_oe, done, ready}, 6'b111001);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 256; i++) begin
      ram[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    last_rd = 8'h00;
    rst_n = 1'b0; valid = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1
    check({cs_n, we_n, oe_n, dq_oe, done, ready} === 6'b111001, "R1 reset state",
          {cs_n, we_n, oe_n, dq_oe, done, ready}, 6'b111001);
    rst_n = 1'b1;
    idle_gap(2);

    // directed corners
    do_read(map_addr(8'h10));
    do_write(19'h00000, 8'h5A);
    do_read(19'h00000);
    do_write(19'h7FFFF, 8'hC3);
    do_read(19'h7FFFF);
    do_write(map_addr(8'h33), 8'h01);
    do_write(map_addr(8'h33), 8'hFE);
    do_read(map_addr(8'h33));
    do_read(map_addr(8'h34));
    idle_gap(3);

    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [7:0] idx;
      idx = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 1) == 1) begin
        d = 8'($urandom_range(0, 255));
        if (d == 8'hEE) d = 8'h11;
        do_write(map_addr(idx), d);
      end else begin
        do_read(map_addr(idx));
      end
      if ($urandom_range(0, 3) == 0) idle_gap(int'($urandom_range(1, 2)));
    end

    summary();
    $finish;
  end

endmodule